// File: doc/BRIEF.md
# Interrupt Vector Source Selector

This block decides, for every interrupt vector fetch the CPU makes, whether the vector word comes from the peripheral expansion vector table or from the default vector table held in boot ROM. A single enable bit in a control register makes the choice. The reset vector is the one exception: it is always served from boot ROM, whatever the enable bit holds. The choice is presented on a combinational table-select output in the same cycle as the fetch request, so the vector memory multiplexer can act on it at once.

Every fetch that is steered to the expansion table leaves its word address in the upper fifteen bits of the control register, with the address's least significant bit dropped. Software reads this field to tell which interrupt produced the most recent vector. The block also holds a twelve-bit acknowledge register whose bits come out of reset set and are cleared by writing ones. It stays fully accessible while the expansion table is disabled.

Top module: `vector_source_select`

## Requirements
- R1: After reset the control register (offset 0) reads 0x0000 and the acknowledge register (offset 1) reads 0x0FFF.
- R2: Control bit 0 is the expansion-table enable. A write to offset 0 loads it from write-data bit 0, and a read returns the stored value.
- R3: While the enable is 0, `table_sel` is 0 (boot ROM) for every fetch.
- R4: While the enable is 1, a fetch with `fetch_reset` low drives `table_sel` to 1 (expansion table) in the same cycle.
- R5: A fetch with `fetch_reset` high drives `table_sel` to 0 even when the enable is 1.
- R6: In the cycle after a fetch steered to the expansion table, control bits 15:1 read back as bits 15:1 of that fetch's address. Address bit 0 is discarded.
- R7: A fetch steered to boot ROM leaves control bits 15:1 unchanged.
- R8: Write data in bits 15:1 of a control-register write has no effect on the value read back.
- R9: Writing a 1 to an acknowledge bit (11:0) clears it, and writing a 0 leaves it unchanged. Acknowledge bits 15:12 always read 0, and no bit is set again except by reset.
- R10: Acknowledge writes take effect while the enable is 0.
- R11: With `fetch_req` low, `table_sel` is 0. Reads with `bus_sel` low, or reads of offsets other than 0 and 1, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register offset: 0 control, 1 acknowledge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| fetch_req | input | 1 | A vector fetch is in progress this cycle |
| fetch_reset | input | 1 | The fetch is for the reset vector |
| fetch_addr | input | 16 | Word address of the vector being fetched |
| table_sel | output | 1 | 1 = expansion table, 0 = boot ROM |

## Verification
The hardest case to reach from the ports is a reset-vector fetch while the enable is set, in the same cycle as a register write. In that case the captured field must not move, the enable must still update, and `table_sel` must stay low. The random phase draws the reset flag, the enable writes and the fetches independently, with a bias that keeps the enable set most of the time. Directed cases then pin down odd addresses, ignored upper write bits, and acknowledge clears while disabled.

// File: rtl/ivs_pkg.sv
package ivs_pkg;

    localparam int DATA_W = 16;
    localparam int ACK_W  = 12;
    localparam int REG_AW = 2;
    localparam int CAP_W  = DATA_W - 1;

    typedef enum logic [REG_AW-1:0] {
        REG_CTRL = 2'd0,
        REG_ACK  = 2'd1
    } reg_sel_e;

    typedef enum logic {
        SRC_BOOT = 1'b0,
        SRC_EXP  = 1'b1
    } src_e;

    typedef struct packed {
        logic              req;
        logic              is_reset;
        logic [DATA_W-1:0] addr;
    } fetch_t;

    typedef struct packed {
        logic [CAP_W-1:0] cap;
        logic             en;
    } ctrl_t;

    function automatic src_e pick_src(input fetch_t f, input logic en);
        return (f.req && en && !f.is_reset) ? SRC_EXP : SRC_BOOT;
    endfunction

endpackage

// File: rtl/ivs_steer.sv
module ivs_steer
    import ivs_pkg::*;
(
    input  fetch_t           fetch,
    input  logic             en,
    output src_e             src,
    output logic             cap_stb,
    output logic [CAP_W-1:0] cap_addr
);
    always_comb begin
        src      = pick_src(fetch, en);
        cap_stb  = (src == SRC_EXP);
        cap_addr = fetch.addr[DATA_W-1:1];
    end
endmodule

// File: rtl/ivs_ctrl_reg.sv
module ivs_ctrl_reg
    import ivs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic             cap_stb,
    input  logic [CAP_W-1:0] cap_addr,
    output ctrl_t            q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (wr_en)
                q.en <= wr_bit;
            if (cap_stb)
                q.cap <= cap_addr;
        end
    end
endmodule

// File: rtl/ivs_ack_reg.sv
module ivs_ack_reg #(
    parameter int WIDTH = ivs_pkg::ACK_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '1;
        else if (wr_en)
            q <= q & ~clr_mask;
    end
endmodule

// File: rtl/vector_source_select.sv
module vector_source_select
    import ivs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              fetch_req,
    input  logic              fetch_reset,
    input  logic [DATA_W-1:0] fetch_addr,
    output logic              table_sel
);
    fetch_t           fetch;
    ctrl_t            ctrl_q;
    src_e             src;
    logic             cap_stb;
    logic [CAP_W-1:0] cap_addr;
    logic             en_w;
    logic [CAP_W-1:0] cap_w;
    logic [ACK_W-1:0] ack_q;
    logic             wr_ctrl;
    logic             wr_ack;
    reg_sel_e         rsel;

    assign fetch = '{req: fetch_req, is_reset: fetch_reset, addr: fetch_addr};
    assign en_w  = ctrl_q.en;
    assign cap_w = ctrl_q.cap;
    assign rsel  = reg_sel_e'(bus_addr);

    assign wr_ctrl = bus_sel && bus_wr && (rsel == REG_CTRL);
    assign wr_ack  = bus_sel && bus_wr && (rsel == REG_ACK);

    ivs_steer u_steer (
        .fetch    (fetch),
        .en       (en_w),
        .src      (src),
        .cap_stb  (cap_stb),
        .cap_addr (cap_addr)
    );

    ivs_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_ctrl),
        .wr_bit   (bus_wdata[0]),
        .cap_stb  (cap_stb),
        .cap_addr (cap_addr),
        .q        (ctrl_q)
    );

    ivs_ack_reg #(.WIDTH(ACK_W)) u_ack (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_ack),
        .clr_mask (bus_wdata[ACK_W-1:0]),
        .q        (ack_q)
    );

    assign table_sel = (src == SRC_EXP);

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (rsel)
                REG_CTRL: bus_rdata = {cap_w, en_w};
                REG_ACK:  bus_rdata = {{(DATA_W-ACK_W){1'b0}}, ack_q};
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ivs_checker.sv
module ivs_checker
    import ivs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fetch_req,
    input logic              fetch_reset,
    input logic [DATA_W-1:0] fetch_addr,
    input logic              table_sel,
    input logic              en,
    input logic [CAP_W-1:0]  cap,
    input logic [ACK_W-1:0]  ack,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata
);
    // R3
    boot_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> !table_sel);

    // R4
    exp_when_on_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && en && !fetch_reset) |-> table_sel);

    // R5
    reset_vec_boot_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && fetch_reset) |-> !table_sel);

    // R11
    idle_no_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_req |-> !table_sel);

    // R6
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        table_sel |=> (cap == $past(fetch_addr[DATA_W-1:1])));

    // R7
    hold_on_boot_chk: assert property (@(posedge clk) disable iff (rst)
        !table_sel |=> $stable(cap));

    // R9
    ack_never_sets_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ack & ~$past(ack)) == '0));

    // R9
    ack_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == 2'd1) |-> (bus_rdata[DATA_W-1:ACK_W] == '0));
endmodule

bind vector_source_select ivs_checker chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_req   (fetch_req),
    .fetch_reset (fetch_reset),
    .fetch_addr  (fetch_addr),
    .table_sel   (table_sel),
    .en          (en_w),
    .cap         (cap_w),
    .ack         (ack_q),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata)
);

// File: tb/vector_source_select_test.sv
module vector_source_select_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr;
    logic [1:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        fetch_req, fetch_reset;
    logic [15:0] fetch_addr;
    logic        table_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic        m_en;
    logic [14:0] m_cap;
    logic [11:0] m_ack;

    always #4 clk = ~clk;

    vector_source_select uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fetch_req(fetch_req), .fetch_reset(fetch_reset),
        .fetch_addr(fetch_addr), .table_sel(table_sel)
    );

    function automatic logic exp_sel(logic req, logic rv, logic en);
        return req && en && !rv;
    endfunction

    function automatic logic [15:0] exp_rd(logic sel, logic [1:0] a);
        if (!sel)      return 16'h0;
        if (a == 2'd0) return {m_cap, m_en};
        if (a == 2'd1) return {4'h0, m_ack};
        return 16'h0;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_en = 1'b0; m_cap = '0; m_ack = 12'hFFF;
        end else begin
            if (exp_sel(fetch_req, fetch_reset, m_en)) m_cap = fetch_addr[15:1];
            if (bus_sel && bus_wr && bus_addr == 2'd0) m_en = bus_wdata[0];
            if (bus_sel && bus_wr && bus_addr == 2'd1) m_ack = m_ack & ~bus_wdata[11:0];
        end
    endtask

    // drive at negedge, check the combinational outputs, then commit the model at posedge
    task automatic cyc(logic r, logic s, logic w, logic [1:0] a, logic [15:0] wd,
                       logic fq, logic fr, logic [15:0] fa, string tag);
        @(negedge clk);
        rst = r; bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = wd;
        fetch_req = fq; fetch_reset = fr; fetch_addr = fa;
        #1;
        if (!r) begin
            string st;
            if (!fq)      st = "R11";
            else if (fr)  st = "R5";
            else if (!m_en) st = "R3";
            else          st = "R4";
            check({st, " table_sel"}, {15'h0, table_sel}, {15'h0, exp_sel(fq, fr, m_en)});
            check({tag, " rdata"}, bus_rdata, exp_rd(s, a));
        end
        @(posedge clk);
        model_edge();
    endtask

    task automatic rd(logic [1:0] a, string tag);
        cyc(1'b0, 1'b1, 1'b0, a, 16'h0, 1'b0, 1'b0, 16'h0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd7));
        m_en = 1'b0; m_cap = '0; m_ack = 12'hFFF;
        rst = 1'b1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        fetch_req = 0; fetch_reset = 0; fetch_addr = 0;
        cyc(1'b1, 0, 0, 0, 0, 0, 0, 0, "R1");
        cyc(1'b1, 0, 0, 0, 0, 0, 0, 0, "R1");
        // R1 reset values
        rd(2'd0, "R1");
        rd(2'd1, "R1");
        // R3 fetch while disabled, R7 capture held
        cyc(0, 0, 0, 0, 0, 1, 0, 16'h1234, "R7");
        rd(2'd0, "R7");
        // R10 ack clear while disabled
        cyc(0, 1, 1, 2'd1, 16'hF00F, 0, 0, 0, "R10");
        rd(2'd1, "R10");
        // R9 zero write keeps bits
        cyc(0, 1, 1, 2'd1, 16'h0000, 0, 0, 0, "R9");
        rd(2'd1, "R9");
        // R2 + R8 enable with junk upper bits
        cyc(0, 1, 1, 2'd0, 16'hFFFF, 0, 0, 0, "R8");
        rd(2'd0, "R8");
        // R6 odd address capture
        cyc(0, 0, 0, 0, 0, 1, 0, 16'h0D27, "R6");
        rd(2'd0, "R6");
        // R5 reset vector with enable set, write in same cycle
        cyc(0, 1, 1, 2'd0, 16'h0001, 1, 1, 16'hBEEF, "R5");
        rd(2'd0, "R7");
        // R2 disable
        cyc(0, 1, 1, 2'd0, 16'h0000, 0, 0, 0, "R2");
        rd(2'd0, "R2");
        rd(2'd2, "R11");
        cyc(0, 0, 0, 2'd0, 0, 0, 0, 0, "R11");

        for (int i = 0; i < 3000; i++) begin
            logic r, s, w, fq, fr;
            logic [1:0] a;
            logic [15:0] wd;
            r  = ($urandom_range(0, 99) == 0);
            s  = $urandom_range(0, 1);
            w  = $urandom_range(0, 1);
            a  = 2'($urandom_range(0, 3));
            wd = 16'($urandom);
            if (a == 2'd0 && $urandom_range(0, 3) != 0) wd[0] = 1'b1;
            if (a == 2'd1 && $urandom_range(0, 3) != 0) wd = 16'h0;
            fq = $urandom_range(0, 3) != 0;
            fr = $urandom_range(0, 4) == 0;
            cyc(r, s, w, a, wd, fq, fr, 16'($urandom), (a == 2'd1) ? "R9" : "R6");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule